// File: doc/BRIEF.md
# External Interrupt Sense and Pending Unit

This unit watches eight active-low external interrupt pins and turns them into interrupt requests for a processor. Every pin has its own sense setting: low level or falling edge. Each pin passes through a synchroniser before detection. In edge mode, each detected event is held as pending until software clears it. Software reaches four 32-bit registers through a plain register port: pending, mask, force and sense. Writes take effect at a clock edge. Reads are combinational on the selected address.

The unit drives two outputs. The first is a combined request, the OR of every enabled pending pin. The second is a separate machine-check request, which pin 0 drives once a routing bit steers it away from the combined request. Arbitration between pins and vector generation are outside this block.

Each pin has a two-state cell. In state `PS_QUIET` no edge event is held. In state `PS_LATCHED` an edge event is held. The transitions are:
- *latch*: `PS_QUIET`→`PS_LATCHED` on a falling edge or an active force bit while in edge mode.
- *acknowledge*: `PS_LATCHED`→`PS_QUIET` on a write-1 clear with no new event in the same cycle.
- *sense-drop*: `PS_LATCHED`→`PS_QUIET` when the pin is switched to level mode.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After reset, all four registers read 0, and `irq_req` and `mchk_req` are 0.
- R2: The register addresses are 0 = pending, 1 = mask, 2 = force and 3 = sense. In the pending, mask and force registers, pin n is bit 31-n. In the sense register, pin n is bit 15-n. Mask bit 0 is the machine-check routing bit. Every other bit reads 0, and written values read back.
- R3: With a sense bit of 0 (level mode), a pin's pending bit is 1 exactly while the synchronised pin is low. A write-1 to that pending bit has no lasting effect.
- R4: With a sense bit of 1 (edge mode), a high-to-low transition sets the pending bit. The bit stays set after the pin returns high. A pin that stays low sets nothing new.
- R5: Writing 1 to an edge-mode pending bit clears it. Writing 0 leaves it unchanged.
- R6: If a falling edge is detected in the same cycle as a write-1 clear of that bit, the pending bit stays set.
- R7: A mask bit of 0 blocks the pin from the request outputs and leaves its pending bit intact.
- R8: A force bit of 1 makes the pin assert. In level mode, pending reads 1 while the force bit is set. In edge mode, the force bit latches pending, which stays set after the force bit is cleared.
- R9: `irq_req` is 1 exactly when some pin that is not routed to machine check has both its pending bit and its mask bit set.
- R10: With the routing bit set, pin 0 drives `mchk_req` (still gated by its mask bit) and no longer contributes to `irq_req`. With the routing bit clear, `mchk_req` stays 0.
- R11: A pin change sampled at clock edge E1 shows on level-mode pending after edge E2, and on edge-mode pending after edge E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin_n | input | 8 | Asynchronous active-low interrupt pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_req | output | 1 | Combined interrupt request |
| mchk_req | output | 1 | Machine-check request from pin 0 |

## Verification
Four kinds of rule are checked by assertions on every cycle:
- the per-pin state rules: a held event survives without a clear, an edge beats a simultaneous clear, a clear with no event empties the cell, and force latches in edge mode;
- silence of both outputs when every mask bit is clear;
- the exclusion of routed pin 0 from the combined request;
- the stability of the sense setting between writes.

Only the bench scenarios can show the rest. This covers the exact latency of the synchroniser, the bit positions of the register map, and that a level-mode clear has no lasting effect. It also covers the end-to-end path from a pin wiggle to each request output.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int ROUTE_BIT = 0;
    localparam int SENSE_TOP = 15;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND  = 2'd0,
        REG_MASK  = 2'd1,
        REG_FORCE = 2'd2,
        REG_SENSE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PS_QUIET   = 1'b0,
        PS_LATCHED = 1'b1
    } pin_state_e;

    // MSB-first placement of pin n in pending/mask/force
    function automatic int pin_bit(int n);
        return DATA_W - 1 - n;
    endfunction

    // reversed placement of pin n in the sense register
    function automatic int sense_bit(int n);
        return SENSE_TOP - n;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // pins idle high, so the chain resets to the idle level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_pin_cell.sv
module ext_irq_pin_cell
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync_i,
    input  logic edge_mode_i,
    input  logic force_i,
    input  logic ack_i,
    output logic pending_o
);

    logic       prev_q;
    logic       fall;
    logic       set_evt;
    pin_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_sync_i;
    end

    assign fall    = prev_q & ~pin_sync_i;
    assign set_evt = fall | force_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_QUIET;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_QUIET: begin
                if (edge_mode_i && set_evt) st_d = PS_LATCHED;       // latch
            end
            PS_LATCHED: begin
                if (!edge_mode_i)             st_d = PS_QUIET;      // sense-drop
                else if (ack_i && !set_evt)   st_d = PS_QUIET;      // acknowledge
            end
            default: st_d = PS_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        if (edge_mode_i) pending_o = (st_q == PS_LATCHED);
        else             pending_o = ~pin_sync_i | force_i;
    end

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && st_q == PS_LATCHED && !ack_i) |=> st_q == PS_LATCHED); // R4
    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && fall && ack_i) |=> st_q == PS_LATCHED); // R6
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && ack_i && !fall && !force_i) |=> st_q == PS_QUIET); // R5
    AST_FORCE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && force_i) |=> st_q == PS_LATCHED); // R8

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_PINS-1:0] pending_i,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] force_o,
    output logic [NUM_PINS-1:0] edge_o,
    output logic                route_o,
    output logic [NUM_PINS-1:0] ack_o,
    output logic [DATA_W-1:0]   rdata_o
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wr_pin;
    logic [NUM_PINS-1:0] wr_sense;
    logic [NUM_PINS-1:0] mask_q, force_q, edge_q;
    logic                route_q;

    assign sel = reg_sel_e'(addr_i);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
        assign wr_pin[g]   = wdata_i[pin_bit(g)];
        assign wr_sense[g] = wdata_i[sense_bit(g)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            force_q <= '0;
            edge_q  <= '0;
            route_q <= 1'b0;
        end else if (wr_en_i) begin
            unique case (sel)
                REG_MASK: begin
                    mask_q  <= wr_pin;
                    route_q <= wdata_i[ROUTE_BIT];
                end
                REG_FORCE: force_q <= wr_pin;
                REG_SENSE: edge_q  <= wr_sense;
                default: ;
            endcase
        end
    end

    assign ack_o   = (wr_en_i && sel == REG_PEND) ? wr_pin : '0;
    assign mask_o  = mask_q;
    assign force_o = force_q;
    assign edge_o  = edge_q;
    assign route_o = route_q;

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_PEND:  for (int n = 0; n < NUM_PINS; n++) rdata_o[pin_bit(n)] = pending_i[n];
            REG_MASK: begin
                for (int n = 0; n < NUM_PINS; n++) rdata_o[pin_bit(n)] = mask_q[n];
                rdata_o[ROUTE_BIT] = route_q;
            end
            REG_FORCE: for (int n = 0; n < NUM_PINS; n++) rdata_o[pin_bit(n)] = force_q[n];
            REG_SENSE: for (int n = 0; n < NUM_PINS; n++) rdata_o[sense_bit(n)] = edge_q[n];
            default: ;
        endcase
    end

    AST_SENSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && sel == REG_SENSE) |=> $stable(edge_q)); // R2

endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_req,
    output logic                mchk_req
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] mask_vec, force_vec, edge_vec, ack_vec;
    logic [NUM_PINS-1:0] route_vec;
    logic                route;

    ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_pin_n),
        .q_o   (pin_sync)
    );

    ext_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .pending_i (pending),
        .mask_o    (mask_vec),
        .force_o   (force_vec),
        .edge_o    (edge_vec),
        .route_o   (route),
        .ack_o     (ack_vec),
        .rdata_o   (reg_rdata)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        ext_irq_pin_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_sync_i  (pin_sync[g]),
            .edge_mode_i (edge_vec[g]),
            .force_i     (force_vec[g]),
            .ack_i       (ack_vec[g]),
            .pending_o   (pending[g])
        );
    end

    assign route_vec = NUM_PINS'(route);
    assign irq_req   = |(pending & mask_vec & ~route_vec);
    assign mchk_req  = route & pending[0] & mask_vec[0];

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |-> (!irq_req && !mchk_req)); // R7
    AST_ROUTED_PIN_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        (route && ((pending & mask_vec) >> 1) == '0) |-> !irq_req); // R10
    AST_MCHK_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !route |-> !mchk_req); // R10

endmodule

// File: tb/ext_irq_sense_unit_bench.sv
module ext_irq_sense_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_pin_n = 8'hFF;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req, mchk_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sense_unit u_ext_irq_sense_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin_n (ext_pin_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .mchk_req  (mchk_req)
    );

    localparam logic [1:0] A_PEND = 2'd0, A_MASK = 2'd1, A_FORCE = 2'd2, A_SENSE = 2'd3;

    function automatic logic [31:0] pb(int n);
        return 32'h1 << (31 - n);
    endfunction
    function automatic logic [31:0] sb(int n);
        return 32'h1 << (15 - n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 irq_req after reset", {31'b0, irq_req}, 32'h0);
        chk("R1 mchk_req after reset", {31'b0, mchk_req}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v);  chk("R2 mask readback", v, 32'hFF00_0001);
        wr(A_SENSE, 32'hFFFF_FFFF);
        rd(A_SENSE, v); chk("R2 sense readback", v, 32'h0000_FF00);
        wr(A_FORCE, pb(3));
        rd(A_FORCE, v); chk("R2 force readback", v, pb(3));
        wr(A_FORCE, 32'h0);
        wr(A_SENSE, 32'h0);
        wr(A_MASK, 32'h0);
        rd(A_PEND, v);  chk("R2 pending idle", v, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        @(negedge clk); ext_pin_n[2] = 1'b0;
        @(negedge clk); rd(A_PEND, v); chk("R11 level after E1", v, 32'h0);
        @(negedge clk); rd(A_PEND, v); chk("R11 level after E2", v, pb(2));
        wr(A_PEND, pb(2));
        idle(1);
        rd(A_PEND, v); chk("R3 level ack no effect", v, pb(2));
        ext_pin_n[2] = 1'b1;
        idle(3);
        rd(A_PEND, v); chk("R3 level follows pin high", v, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(A_SENSE, sb(5));
        ext_pin_n[5] = 1'b0;
        @(negedge clk);
        @(negedge clk); rd(A_PEND, v); chk("R11 edge after E2", v, 32'h0);
        @(negedge clk); rd(A_PEND, v); chk("R11 edge after E3", v, pb(5));
        ext_pin_n[5] = 1'b1;
        idle(4);
        rd(A_PEND, v); chk("R4 edge held after pin high", v, pb(5));
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr(A_PEND, 32'h00FF_FFFF);
        rd(A_PEND, v); chk("R5 write 0 keeps pending", v, pb(5));
        wr(A_PEND, pb(5));
        rd(A_PEND, v); chk("R5 write 1 clears", v, 32'h0);
    endtask

    task automatic t_edge_vs_ack;
        logic [31:0] v;
        ext_pin_n[5] = 1'b0; idle(3);
        ext_pin_n[5] = 1'b1; idle(3);
        rd(A_PEND, v); chk("R4 second edge latched", v, pb(5));
        ext_pin_n[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = A_PEND; reg_wdata = pb(5); reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rd(A_PEND, v); chk("R6 edge beats clear", v, pb(5));
        wr(A_PEND, pb(5));
        idle(2);
        rd(A_PEND, v); chk("R4 held low no new event", v, 32'h0);
        ext_pin_n[5] = 1'b1; idle(3);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        ext_pin_n[1] = 1'b0; idle(3);
        chk("R7 masked no irq", {31'b0, irq_req}, 32'h0);
        rd(A_PEND, v); chk("R7 masked pending kept", v, pb(1));
        wr(A_MASK, pb(6));
        chk("R9 other pin enabled no irq", {31'b0, irq_req}, 32'h0);
        wr(A_MASK, pb(6) | pb(1));
        chk("R9 enabled pending raises irq", {31'b0, irq_req}, 32'h1);
        wr(A_MASK, 32'h0);
        chk("R7 mask cleared drops irq", {31'b0, irq_req}, 32'h0);
        ext_pin_n[1] = 1'b1; idle(3);
    endtask

    task automatic t_force;
        logic [31:0] v;
        wr(A_FORCE, pb(4));
        rd(A_PEND, v); chk("R8 level force sets pending", v, pb(4));
        wr(A_MASK, pb(4));
        chk("R8 forced irq", {31'b0, irq_req}, 32'h1);
        wr(A_FORCE, 32'h0);
        rd(A_PEND, v); chk("R8 level force released", v, 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_FORCE, pb(5));
        idle(1);
        wr(A_FORCE, 32'h0);
        idle(1);
        rd(A_PEND, v); chk("R8 edge force latched", v, pb(5));
        wr(A_PEND, pb(5));
        rd(A_PEND, v); chk("R5 forced event cleared", v, 32'h0);
    endtask

    task automatic t_route;
        logic [31:0] v;
        wr(A_SENSE, sb(0) | sb(5));
        wr(A_MASK, pb(0) | 32'h1);
        ext_pin_n[0] = 1'b0; idle(3);
        rd(A_PEND, v); chk("R4 pin0 edge via bit 15", v, pb(0));
        chk("R10 routed mchk", {31'b0, mchk_req}, 32'h1);
        chk("R10 routed no irq", {31'b0, irq_req}, 32'h0);
        wr(A_MASK, pb(0));
        chk("R10 unrouted no mchk", {31'b0, mchk_req}, 32'h0);
        chk("R9 unrouted pin0 irq", {31'b0, irq_req}, 32'h1);
        wr(A_PEND, pb(0));
        chk("R5 cleared drops irq", {31'b0, irq_req}, 32'h0);
        ext_pin_n[0] = 1'b1; idle(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_regmap;
        t_level;
        t_edge;
        t_ack;
        t_edge_vs_ack;
        t_mask;
        t_force;
        t_route;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule